// File: doc/BRIEF.md
# I2C Target Address Matcher with Software-Reset Call

This block makes the per-byte acknowledge decision for an I2C target. A bit-level engine sits in front of it and handles line sampling. That engine hands over a start pulse, a stop pulse, a received byte with a valid strobe, and a flag telling whether the byte is the first one since the last start. The matcher answers each byte with a registered acknowledge decision. It also tracks whether the device is currently addressed and in which direction.

The first byte of a transfer is compared against several 7-bit addresses:
- a regular address taken from pins;
- a programmable group (all-call) address with its own enable;
- three programmable subaddresses, each with its own enable.

Only bits 7:1 of each programmed address byte take part in the comparison. The seven-bit address 1101011 is reserved for a software-reset call and never counts as an ordinary match. A write to that address (byte D6h) must be followed by exactly two key bytes, A5h then 5Ah, and then a Stop. When that whole sequence completes, the block emits a one-cycle reset pulse for the rest of the device. Register storage and read data live outside this block.

Top module: `i2c_addr_match`

## Requirements
- R1: A first byte equal to D6h (reserved address 1101011, direction bit 0) is acknowledged and opens a reset call. A first byte of D7h (same address, direction bit 1) is not acknowledged.
- R2: Within a reset call, the second byte is acknowledged only if it equals A5h, and the third only if it equals 5Ah. Any other value is not acknowledged and aborts the call.
- R3: After both key bytes, every further byte in the call is not acknowledged, and the call is aborted.
- R4: `swrst_o` pulses high for exactly one cycle, in the cycle after `stop_i`, only when both key bytes were acknowledged and no other byte or start came between them and the Stop.
- R5: A first byte whose bits 7:1 equal `own_addr_i` is acknowledged for both directions. Bit 0 is captured on `rd_o` (1 = read). `addressed_o` stays high until the next start or stop, which also clear `rd_o`.
- R6: The group address is acknowledged for read and write while `gcall_en_i` is 1, and never while it is 0.
- R7: Subaddress k, held in bits 8k+7:8k of `sub_addr_i`, is acknowledged only while `sub_en_i[k]` is 1.
- R8: Bit 0 of `gcall_addr_i` and of each subaddress byte has no effect on matching.
- R9: Address 1101011 is never matched as the regular, group or subaddress, even when configured as one of them.
- R10: A byte that is not first and arrives with no active match or reset call is not acknowledged. The matcher then ignores bytes until the next start.
- R11: `ack_vld_o` and `ack_o` are registered: they are valid in the cycle after `byte_vld_i`. While addressed, data bytes are acknowledged in write direction and not acknowledged in read direction. Start and stop take precedence over a byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start or repeated-start event pulse |
| stop_i | input | 1 | Stop event pulse |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| first_i | input | 1 | Byte is the first since start |
| own_addr_i | input | 7 | Regular 7-bit address |
| gcall_addr_i | input | 8 | Group address byte, bits 7:1 used |
| gcall_en_i | input | 1 | Group address enable |
| sub_addr_i | input | 24 | Three subaddress bytes, bits 7:1 of each used |
| sub_en_i | input | 3 | Per-subaddress enables |
| ack_vld_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | Acknowledge (1) or not (0) |
| addressed_o | output | 1 | Device currently selected |
| rd_o | output | 1 | Captured direction bit |
| swrst_o | output | 1 | One-cycle software-reset pulse |

## Verification
The bench targets every way a reset call can be cut short:
- a wrong first or second key;
- an extra third data byte;
- a repeated start before the Stop;
- a Stop right after the address.

A design that counted acknowledged bytes loosely, or fired on any Stop after D6h, would pulse `swrst_o` in one of these cases.

It also programs the reserved address as the regular and group address. A matcher that skipped the reservation would then acknowledge D7h.

Further checks:
- Sticky idle after an unmatched first byte. A design that re-evaluated later bytes as addresses would wrongly acknowledge an embedded D6h.
- Bit 0 set in a programmed subaddress. A full 8-bit comparison would reject the write form of that address.

// File: rtl/i2c_match_pkg.sv
package i2c_match_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MATCH,
        ST_KEY1,
        ST_KEY2,
        ST_ARMED,
        ST_DEAD
    } mstate_e;

    typedef struct packed {
        mstate_e st;
        logic    rd;
        logic    ack;
        logic    vld;
        logic    rst;
    } mreg_t;

endpackage

// File: rtl/i2c_slot_cmp.sv
module i2c_slot_cmp #(
    parameter int NSLOT = 5,
    parameter int AW = 7,
    parameter logic [AW-1:0] RESV = 7'h6B
) (
    input  logic [NSLOT-1:0][AW-1:0] slot_addr_i,
    input  logic [NSLOT-1:0]         slot_en_i,
    input  logic [AW-1:0]            probe_i,
    output logic                     hit_o
);
    logic [NSLOT-1:0] hits;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign hits[s] = slot_en_i[s] && (slot_addr_i[s] == probe_i);
    end

    // the reserved address is never an ordinary match
    assign hit_o = (|hits) && (probe_i != RESV);
endmodule

// File: rtl/i2c_key_chk.sv
module i2c_key_chk #(
    parameter int BW = 8,
    parameter logic [BW-1:0] KEY_A = 8'hA5,
    parameter logic [BW-1:0] KEY_B = 8'h5A
) (
    input  logic [BW-1:0] byte_i,
    output logic          a_ok_o,
    output logic          b_ok_o
);
    assign a_ok_o = (byte_i == KEY_A);
    assign b_ok_o = (byte_i == KEY_B);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_match_pkg::*;
#(
    parameter int NSUB = 3,
    parameter logic [ADDR_W-1:0] RST_ADDR = 7'h6B,
    parameter logic [BYTE_W-1:0] KEY_A = 8'hA5,
    parameter logic [BYTE_W-1:0] KEY_B = 8'h5A
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     stop_i,
    input  logic                     byte_vld_i,
    input  logic [BYTE_W-1:0]        byte_i,
    input  logic                     first_i,
    input  logic [ADDR_W-1:0]        own_addr_i,
    input  logic [BYTE_W-1:0]        gcall_addr_i,
    input  logic                     gcall_en_i,
    input  logic [NSUB*BYTE_W-1:0]   sub_addr_i,
    input  logic [NSUB-1:0]          sub_en_i,
    output logic                     ack_vld_o,
    output logic                     ack_o,
    output logic                     addressed_o,
    output logic                     rd_o,
    output logic                     swrst_o
);
    localparam int NSLOT = 2 + NSUB;

    logic [NSLOT-1:0][ADDR_W-1:0] slot_addr;
    logic [NSLOT-1:0]             slot_en;
    logic                         addr_hit;
    logic                         key_a_ok;
    logic                         key_b_ok;
    mreg_t                        q, d;

    assign slot_addr[0] = own_addr_i;
    assign slot_en[0]   = 1'b1;
    assign slot_addr[1] = gcall_addr_i[BYTE_W-1:1];
    assign slot_en[1]   = gcall_en_i;

    for (genvar k = 0; k < NSUB; k++) begin : g_sub
        assign slot_addr[2+k] = sub_addr_i[k*BYTE_W+1 +: ADDR_W];
        assign slot_en[2+k]   = sub_en_i[k];
    end

    i2c_slot_cmp #(.NSLOT(NSLOT), .AW(ADDR_W), .RESV(RST_ADDR)) u_cmp (
        .slot_addr_i (slot_addr),
        .slot_en_i   (slot_en),
        .probe_i     (byte_i[BYTE_W-1:1]),
        .hit_o       (addr_hit)
    );

    i2c_key_chk #(.BW(BYTE_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
        .byte_i (byte_i),
        .a_ok_o (key_a_ok),
        .b_ok_o (key_b_ok)
    );

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        d.ack = 1'b0;
        d.rst = 1'b0;
        if (start_i) begin
            d.st = ST_IDLE;
            d.rd = 1'b0;
        end else if (stop_i) begin
            d.rst = (q.st == ST_ARMED);
            d.st  = ST_IDLE;
            d.rd  = 1'b0;
        end else if (byte_vld_i) begin
            d.vld = 1'b1;
            if (first_i) begin
                if (byte_i == {RST_ADDR, 1'b0}) begin
                    d.st  = ST_KEY1;
                    d.ack = 1'b1;
                end else if (addr_hit) begin
                    d.st  = ST_MATCH;
                    d.rd  = byte_i[0];
                    d.ack = 1'b1;
                end else begin
                    d.st = ST_DEAD;
                end
            end else begin
                unique case (q.st)
                    ST_MATCH: d.ack = ~q.rd;
                    ST_KEY1: begin
                        d.st  = key_a_ok ? ST_KEY2 : ST_DEAD;
                        d.ack = key_a_ok;
                    end
                    ST_KEY2: begin
                        d.st  = key_b_ok ? ST_ARMED : ST_DEAD;
                        d.ack = key_b_ok;
                    end
                    default: d.st = ST_DEAD;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, rd: 1'b0, ack: 1'b0, vld: 1'b0, rst: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign ack_vld_o   = q.vld;
    assign ack_o       = q.ack;
    assign addressed_o = (q.st == ST_MATCH);
    assign rd_o        = q.rd;
    assign swrst_o     = q.rst;
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       stop_i,
    input logic       byte_vld_i,
    input logic [7:0] byte_i,
    input logic       first_i,
    input logic       ack_vld_o,
    input logic       ack_o,
    input logic       addressed_o,
    input logic       swrst_o
);
    // R4
    swrst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_o |=> !swrst_o);

    // R4
    swrst_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_o |-> $past(stop_i));

    // R11
    ack_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld_o |-> $past(byte_vld_i && !start_i && !stop_i));

    // R11
    ack_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ack_vld_o);

    // R5
    start_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i || stop_i) |=> !addressed_o);

    // R1
    rsv_read_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && first_i && !start_i && !stop_i && byte_i == 8'hD7) |=> !ack_o);
endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .byte_vld_i  (byte_vld_i),
    .byte_i      (byte_i),
    .first_i     (first_i),
    .ack_vld_o   (ack_vld_o),
    .ack_o       (ack_o),
    .addressed_o (addressed_o),
    .swrst_o     (swrst_o)
);

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0, first_i = 1'b0;
    logic [7:0]  byte_i = 8'h00;
    logic [6:0]  own_addr_i = 7'h2A;
    logic [7:0]  gcall_addr_i = 8'hD0;
    logic        gcall_en_i = 1'b1;
    logic [23:0] sub_addr_i = {8'hD8, 8'hD4, 8'hD2};
    logic [2:0]  sub_en_i = 3'b000;
    logic        ack_vld_o, ack_o, addressed_o, rd_o, swrst_o;

    int checks = 0;
    int errors = 0;

    // behavioural reference: mode 0 idle,1 selected,2 want key A,3 want key B,4 armed,5 ignore
    int m_mode = 0;
    bit m_rd = 0, e_ack = 0, e_vld = 0, e_rst = 0;

    always #5 clk = ~clk;

    i2c_addr_match dut_i (.*);

    function automatic bit ref_hit(input logic [7:0] b);
        bit h;
        h = (b[7:1] == own_addr_i);
        if (gcall_en_i && b[7:1] == gcall_addr_i[7:1]) h = 1;
        for (int k = 0; k < 3; k++)
            if (sub_en_i[k] && b[7:1] == sub_addr_i[8*k+1 +: 7]) h = 1;
        if (b[7:1] == 7'h6B) h = 0;
        return h;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_rd = 0; e_ack = 0; e_vld = 0; e_rst = 0;
        end else begin
            e_ack = 0; e_vld = 0; e_rst = 0;
            if (start_i) begin
                m_mode = 0; m_rd = 0;
            end else if (stop_i) begin
                e_rst = (m_mode == 4); m_mode = 0; m_rd = 0;
            end else if (byte_vld_i) begin
                e_vld = 1;
                if (first_i) begin
                    if (byte_i == 8'hD6) begin m_mode = 2; e_ack = 1; end
                    else if (ref_hit(byte_i)) begin m_mode = 1; m_rd = byte_i[0]; e_ack = 1; end
                    else m_mode = 5;
                end else if (m_mode == 1) e_ack = !m_rd;
                else if (m_mode == 2 && byte_i == 8'hA5) begin m_mode = 3; e_ack = 1; end
                else if (m_mode == 3 && byte_i == 8'h5A) begin m_mode = 4; e_ack = 1; end
                else m_mode = 5;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R11 every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check("R11 model ack_vld", ack_vld_o, e_vld);
            check("R11 model ack", ack_o, e_ack);
            check("R5 model addressed", addressed_o, m_mode == 1);
            check("R5 model rd", rd_o, m_rd);
            check("R4 model swrst", swrst_o, e_rst);
        end
    end

    task automatic do_start();
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0;
    endtask

    task automatic do_stop(input string tag, input bit exp_pulse);
        @(negedge clk); stop_i = 1;
        @(negedge clk); stop_i = 0;
        check(tag, swrst_o, exp_pulse);
        @(negedge clk);
        check(tag, swrst_o, 0);
    endtask

    task automatic send(input string tag, input logic [7:0] b, input bit first, input bit exp_ack);
        @(negedge clk); byte_vld_i = 1; byte_i = b; first_i = first;
        @(negedge clk); byte_vld_i = 0; first_i = 0;
        check(tag, ack_vld_o, 1);
        check(tag, ack_o, exp_ack);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R11 reset vld", ack_vld_o, 0);
        check("R5 reset addressed", addressed_o, 0);
        check("R4 reset swrst", swrst_o, 0);

        // R10: byte with no start/match
        send("R10 stray byte", 8'h54, 0, 0);
        // R5 write
        do_start();
        send("R5 own write", 8'h54, 1, 1);
        check("R5 addressed", addressed_o, 1);
        check("R5 rd write", rd_o, 0);
        send("R11 write data", 8'h11, 0, 1);
        do_stop("R4 no pulse plain stop", 0);
        check("R5 stop clears", addressed_o, 0);
        // R5 read then repeated start
        do_start();
        send("R5 own read", 8'h55, 1, 1);
        check("R5 rd read", rd_o, 1);
        send("R11 read data nack", 8'h00, 0, 0);
        do_start();
        check("R5 restart clears", addressed_o, 0);
        // R6
        send("R6 group write", 8'hD0, 1, 1);
        do_start();
        send("R6 group read", 8'hD1, 1, 1);
        gcall_en_i = 0;
        do_start();
        send("R6 group disabled", 8'hD0, 1, 0);
        // R10: later bytes ignored, even D6
        send("R10 after miss", 8'hD6, 0, 0);
        send("R10 after miss own", 8'h54, 0, 0);
        // R7
        do_start();
        send("R7 sub disabled", 8'hD2, 1, 0);
        sub_en_i = 3'b010;
        do_start();
        send("R7 sub2 enabled", 8'hD4, 1, 1);
        do_start();
        send("R7 sub1 still off", 8'hD2, 1, 0);
        do_start();
        send("R7 sub3 still off", 8'hD8, 1, 0);
        // R8
        sub_addr_i[7:0] = 8'hE3; sub_en_i = 3'b011;
        do_start();
        send("R8 bit0 ignored write", 8'hE2, 1, 1);
        do_start();
        send("R8 bit0 ignored read", 8'hE3, 1, 1);
        do_stop("R4 no pulse R8", 0);
        // R9
        own_addr_i = 7'h6B;
        do_start();
        send("R9 reserved own read", 8'hD7, 1, 0);
        gcall_addr_i = 8'hD6; gcall_en_i = 1;
        do_start();
        send("R9 reserved group read", 8'hD7, 1, 0);
        do_start();
        send("R1 reserved write", 8'hD6, 1, 1);
        check("R9 not addressed", addressed_o, 0);
        do_stop("R4 stop after address only", 0);
        own_addr_i = 7'h2A; gcall_addr_i = 8'hD0;
        // R1/R2/R4 full call
        do_start();
        send("R1 rst addr", 8'hD6, 1, 1);
        send("R2 key A", 8'hA5, 0, 1);
        send("R2 key B", 8'h5A, 0, 1);
        do_stop("R4 pulse", 1);
        // R2 mismatch
        do_start();
        send("R1 rst addr 2", 8'hD6, 1, 1);
        send("R2 bad key A", 8'hA4, 0, 0);
        send("R2 after abort", 8'h5A, 0, 0);
        do_stop("R4 no pulse bad A", 0);
        do_start();
        send("R1 rst addr 3", 8'hD6, 1, 1);
        send("R2 key A 3", 8'hA5, 0, 1);
        send("R2 bad key B", 8'hA5, 0, 0);
        do_stop("R4 no pulse bad B", 0);
        // R3 extra byte
        do_start();
        send("R1 rst addr 4", 8'hD6, 1, 1);
        send("R2 key A 4", 8'hA5, 0, 1);
        send("R2 key B 4", 8'h5A, 0, 1);
        send("R3 extra byte", 8'h00, 0, 0);
        do_stop("R3 no pulse extra", 0);
        // R4 repeated start kills call
        do_start();
        send("R1 rst addr 5", 8'hD6, 1, 1);
        send("R2 key A 5", 8'hA5, 0, 1);
        send("R2 key B 5", 8'h5A, 0, 1);
        do_start();
        do_stop("R4 no pulse restart", 0);
        // R11 start beats byte in same cycle
        @(negedge clk); start_i = 1; byte_vld_i = 1; byte_i = 8'h54; first_i = 1;
        @(negedge clk); start_i = 0; byte_vld_i = 0; first_i = 0;
        check("R11 start precedence", ack_vld_o, 0);
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule